// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block sits beside the core of a small 8-bit microcontroller and decides, at every instruction boundary, whether the core should divert into an interrupt handler and at which address. Twelve sources each own a pending flag, an enable bit and a priority bit (1 = high level, 0 = low level). A single global enable masks every source at once. Pending flags latch on a one-cycle event pulse from the source no matter what the masks say. Flags are cleared only by software.

The core signals each completed instruction with `insn_done`. When a request is eligible the block raises `irq_req` in that same cycle and drives the handler address on `irq_vec`. The core answers with `irq_ack` when it issues the call. Two in-service bits record which levels are active, so a high-level request can interrupt a low-level handler while equal or lower requests wait. A return strobe, given with the boundary of the return instruction, retires the highest active level. A flag left set at return comes back after exactly one more instruction.

Software reaches the flags, enables and priorities through an 8-bit register port with combinational read data.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every pending flag, enable bit, priority bit, the global enable and both in-service bits are 0, every register reads 0x00, and `irq_req` stays low.
- R2: A one-cycle pulse on `src_evt[i]` sets pending flag i whatever the state of its enable bit and of the global enable.
- R3: `irq_req` is high only in a cycle with `insn_done` high, and only for a source whose flag, enable bit and global enable are all 1.
- R4: The global enable is bit 7 of register 0. While it is 0 no request is raised, flags that arrive meanwhile stay pending, and they are requested once it returns to 1.
- R5: Among eligible requests of one level the lowest source index wins. An eligible high-level request beats every low-level one.
- R6: `irq_vec` carries 0x0003 + 8 × index of the winning source (source 0 at 0x0003, source 11 at 0x005B).
- R7: Hardware never clears a pending flag, including when a request is acknowledged; a software write of 0 to its bit is the only way to clear it.
- R8: `reti` is asserted together with `insn_done` at the return instruction's boundary. No request is raised in that cycle. A flag still eligible is requested at the next boundary, after one more instruction.
- R9: `irq_ack` with `irq_req` high sets the in-service bit of the winner's level. While low is in service only high-level requests are raised; while high is in service none are.
- R10: `reti` clears the high in-service bit if it is set, otherwise the low one.
- R11: When a hardware event and a software write target the same flag in the same cycle, the flag ends up set.
- R12: Register map: address 0 holds enables of sources 0..6 in bits 6:0 plus the global enable in bit 7; address 1 holds enables of sources 7..11 in bits 4:0; addresses 2 and 3 hold pending flags of sources 0..7 and 8..11; addresses 4 and 5 hold priority bits in the same layout. Unused bits and addresses read 0. A write loads the addressed bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 12 | One-cycle event pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| insn_done | input | 1 | Core has completed an instruction this cycle |
| irq_req | output | 1 | Take an interrupt at this boundary |
| irq_vec | output | 16 | Handler address of the winning source |
| irq_ack | input | 1 | Core issues the call for the presented request |
| reti | input | 1 | Return-from-interrupt strobe, given with `insn_done` |

## Verification
A corrupted in-service bit shows up at the next boundary where a request is pending: a stuck high bit suppresses every request, and a lost low bit lets a second low request nest. Both are visible on `irq_req` in the same cycle as `insn_done`. A pending flag dropped by mistake is seen at once on a register read. It is also seen as a missing re-entry at the boundary that follows a return. A wrong arbitration or vector slice appears on `irq_vec` in the first boundary cycle where two sources compete.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam int BYTE_W = 8;
  localparam int GE_BIT = BYTE_W - 1;
  localparam int EN_LO_SLOTS = BYTE_W - 1;

  typedef enum logic [0:0] {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;

  // enable bits share register 0 with the global enable
  function automatic int en_addr(input int i);
    return (i < EN_LO_SLOTS) ? 0 : 1 + (i - EN_LO_SLOTS) / BYTE_W;
  endfunction

  function automatic int en_bit(input int i);
    return (i < EN_LO_SLOTS) ? i : (i - EN_LO_SLOTS) % BYTE_W;
  endfunction

  function automatic int fld_addr(input int base, input int i);
    return base + i / BYTE_W;
  endfunction

  function automatic int fld_bit(input int i);
    return i % BYTE_W;
  endfunction

  function automatic int vec_of(input int base, input int step, input int idx);
    return base + step * idx;
  endfunction

endpackage

// File: rtl/pic_regs.sv
module pic_regs #(
  parameter int N_SRC     = 12,
  parameter int ADDR_W    = 3,
  parameter int PEND_BASE = 2,
  parameter int PRIO_BASE = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SRC-1:0]          src_evt,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [pic_pkg::BYTE_W-1:0] wdata,
  output logic [pic_pkg::BYTE_W-1:0] rdata,
  output logic [N_SRC-1:0]          pend_q,
  output logic [N_SRC-1:0]          en_q,
  output logic [N_SRC-1:0]          prio_q,
  output logic                      ge_q
);
  import pic_pkg::*;

  logic ge_hit;
  assign ge_hit = we && (addr == ADDR_W'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ge_q <= 1'b0;
    else if (ge_hit) ge_q <= wdata[GE_BIT];
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    logic pend_hit, en_hit, prio_hit;
    assign pend_hit = we && (addr == ADDR_W'(fld_addr(PEND_BASE, i)));
    assign en_hit   = we && (addr == ADDR_W'(en_addr(i)));
    assign prio_hit = we && (addr == ADDR_W'(fld_addr(PRIO_BASE, i)));

    // hardware event outranks a software write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else if (src_evt[i]) pend_q[i] <= 1'b1;
      else if (pend_hit) pend_q[i] <= wdata[fld_bit(i)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[i] <= 1'b0;
      else if (en_hit) en_q[i] <= wdata[en_bit(i)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_q[i] <= 1'b0;
      else if (prio_hit) prio_q[i] <= wdata[fld_bit(i)];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(0)) rdata[GE_BIT] = ge_q;
    for (int i = 0; i < N_SRC; i++) begin
      if (addr == ADDR_W'(en_addr(i)))             rdata[en_bit(i)]  = en_q[i];
      if (addr == ADDR_W'(fld_addr(PEND_BASE, i))) rdata[fld_bit(i)] = pend_q[i];
      if (addr == ADDR_W'(fld_addr(PRIO_BASE, i))) rdata[fld_bit(i)] = prio_q[i];
    end
  end

endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int N_SRC    = 12,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  localparam int IDX_W   = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] en,
  input  logic [N_SRC-1:0] prio,
  input  logic             ge,
  input  logic [1:0]       isv,
  output logic             valid,
  output logic             win_hi,
  output logic [IDX_W-1:0] win_idx,
  output logic [VEC_W-1:0] win_vec
);
  import pic_pkg::*;

  function automatic logic [IDX_W-1:0] first_set(input logic [N_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_SRC - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [N_SRC-1:0] cand, cand_hi, cand_lo;
  logic hi_ok, lo_ok;

  assign cand    = pend & en & {N_SRC{ge}};
  assign cand_hi = cand & prio;
  assign cand_lo = cand & ~prio;

  assign hi_ok = (|cand_hi) && !isv[LVL_HI];
  assign lo_ok = (|cand_lo) && (isv == 2'b00);

  assign valid   = hi_ok || lo_ok;
  assign win_hi  = hi_ok;
  assign win_idx = hi_ok ? first_set(cand_hi) : first_set(cand_lo);
  assign win_vec = VEC_W'(vec_of(VEC_BASE, VEC_STEP, int'(win_idx)));

endmodule

// File: rtl/pic_svc.sv
module pic_svc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_hi,
  input  logic       ret,
  output logic [1:0] isv
);
  import pic_pkg::*;

  logic [1:0] isv_nxt;

  always_comb begin
    isv_nxt = isv;
    if (ret) begin
      if (isv[LVL_HI]) isv_nxt[LVL_HI] = 1'b0;
      else             isv_nxt[LVL_LO] = 1'b0;
    end
    if (take) isv_nxt[take_hi] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isv <= 2'b00;
    else        isv <= isv_nxt;
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_SRC    = 12,
  parameter int ADDR_W   = 3,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              insn_done,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack,
  input  logic              reti
);
  localparam int IDX_W     = $clog2(N_SRC);
  localparam int EN_REGS   = (N_SRC + 1 + pic_pkg::BYTE_W - 1) / pic_pkg::BYTE_W;
  localparam int FLD_REGS  = (N_SRC + pic_pkg::BYTE_W - 1) / pic_pkg::BYTE_W;
  localparam int PEND_BASE = EN_REGS;
  localparam int PRIO_BASE = PEND_BASE + FLD_REGS;

  // named internal events, observed by the bound checker
  logic [N_SRC-1:0] pend_w, en_w, prio_w;
  logic             ge_w;
  logic [1:0]       isv_w;
  logic             cand_any, win_hi;
  logic [IDX_W-1:0] win_idx;
  logic             take;

  pic_regs #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W), .PEND_BASE(PEND_BASE), .PRIO_BASE(PRIO_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .pend_q(pend_w), .en_q(en_w), .prio_q(prio_w), .ge_q(ge_w)
  );

  pic_arb #(
    .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_arb (
    .pend(pend_w), .en(en_w), .prio(prio_w), .ge(ge_w), .isv(isv_w),
    .valid(cand_any), .win_hi(win_hi), .win_idx(win_idx), .win_vec(irq_vec)
  );

  // the return boundary itself never carries a request
  assign irq_req = insn_done && cand_any && !reti;
  assign take    = irq_ack && irq_req;

  pic_svc u_svc (
    .clk(clk), .rst_n(rst_n), .take(take), .take_hi(win_hi),
    .ret(reti), .isv(isv_w)
  );

endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int N_SRC = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             insn_done,
  input logic             irq_req,
  input logic             irq_ack,
  input logic             reti,
  input logic             reg_we,
  input logic             ge,
  input logic [N_SRC-1:0] pend,
  input logic [1:0]       isv,
  input logic             take,
  input logic             win_hi
);

  AST_REQ_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> insn_done); // R3

  AST_REQ_NEEDS_GE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ge); // R4

  AST_FLAG_NOT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((pend & $past(pend)) == $past(pend))); // R7

  AST_RETI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reti |-> !irq_req); // R8

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> irq_req); // R9

  AST_HI_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    isv[1] |-> !irq_req); // R9

  AST_NEST_ONLY_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (take && isv[0]) |-> win_hi); // R9

  AST_RET_DROPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && isv[1]) |=> (isv == {1'b0, $past(isv[0])})); // R10

  AST_RET_DROPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && isv == 2'b01) |=> (isv == 2'b00)); // R10

endmodule

bind prio_irq_ctrl pic_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_req(irq_req),
  .irq_ack(irq_ack), .reti(reti), .reg_we(reg_we), .ge(ge_w),
  .pend(pend_w), .isv(isv_w), .take(take), .win_hi(win_hi)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] src_evt = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        insn_done = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic        irq_ack = 1'b0;
  logic        reti = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .insn_done(insn_done), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .reti(reti)
  );

  typedef struct packed {
    logic [11:0] pend;
    logic [11:0] en;
    logic [11:0] prio;
    logic        ge;
    logic        req;
    logic [3:0]  idx;
  } vec_t;

  // covers R3, R4, R5 and R6 through the vector address
  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{12'h001, 12'h001, 12'h000, 1'b1, 1'b1, 4'd0},
    '{12'h001, 12'h001, 12'h000, 1'b0, 1'b0, 4'd0},
    '{12'h001, 12'h000, 12'h000, 1'b1, 1'b0, 4'd0},
    '{12'h0A0, 12'hFFF, 12'h000, 1'b1, 1'b1, 4'd5},
    '{12'h0A0, 12'hFFF, 12'h080, 1'b1, 1'b1, 4'd7},
    '{12'h800, 12'h800, 12'h000, 1'b1, 1'b1, 4'd11},
    '{12'hC00, 12'h400, 12'h000, 1'b1, 1'b1, 4'd10},
    '{12'hFFF, 12'hFFF, 12'h600, 1'b1, 1'b1, 4'd9},
    '{12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0, 4'd0},
    '{12'h006, 12'h004, 12'h002, 1'b1, 1'b1, 4'd2}
  };

  function automatic int exp_vec(input int idx);
    return 3 + idx * 8;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic probe(output logic rq, output logic [15:0] v);
    @(negedge clk);
    insn_done = 1'b1;
    #1 rq = irq_req; v = irq_vec;
    insn_done = 1'b0;
  endtask

  task automatic take_it();
    @(negedge clk);
    insn_done = 1'b1; irq_ack = 1'b1;
    @(negedge clk);
    insn_done = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic ret_boundary(output logic rq);
    @(negedge clk);
    insn_done = 1'b1; reti = 1'b1;
    #1 rq = irq_req;
    @(negedge clk);
    insn_done = 1'b0; reti = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    src_evt = 12'(1) << idx;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic load(input vec_t v);
    wr(3'd0, {v.ge, v.en[6:0]});
    wr(3'd1, {3'b000, v.en[11:7]});
    wr(3'd4, v.prio[7:0]);
    wr(3'd5, {4'h0, v.prio[11:8]});
    wr(3'd2, v.pend[7:0]);
    wr(3'd3, {4'h0, v.pend[11:8]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic rq;
    logic [15:0] v;
    logic [7:0] d;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1", d, 0);
    end
    probe(rq, v);
    chk("R1", rq, 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      load(TBL[k]);
      probe(rq, v);
      chk("R3/R5", rq, TBL[k].req);
      if (TBL[k].req) chk("R6", v, exp_vec(int'(TBL[k].idx)));
    end
    load('0);

    // R2, R4: flag latches while globally masked, served after unmask
    wr(3'd0, 8'h08);
    pulse(3);
    rd(3'd2, d);
    chk("R2", d, 8'h08);
    probe(rq, v);
    chk("R4", rq, 0);
    wr(3'd0, 8'h88);
    @(negedge clk);
    #1 chk("R3", irq_req, 0);
    probe(rq, v);
    chk("R4", rq, 1);
    chk("R6", v, 16'd27);

    // R7, R9: acknowledged flag remains, low level then blocks low
    take_it();
    rd(3'd2, d);
    chk("R7", d, 8'h08);
    probe(rq, v);
    chk("R9", rq, 0);

    // R9, R5: high-level source 8 preempts the low handler
    wr(3'd5, 8'h01);
    wr(3'd1, 8'h02);
    pulse(8);
    probe(rq, v);
    chk("R9", rq, 1);
    chk("R5", v, 16'd67);
    take_it();
    wr(3'd3, 8'h00);
    rd(3'd3, d);
    chk("R7", d, 0);
    pulse(8);
    probe(rq, v);
    chk("R9", rq, 0);
    wr(3'd3, 8'h00);

    // R8, R10: first return drops the high level only
    ret_boundary(rq);
    chk("R8", rq, 0);
    probe(rq, v);
    chk("R10", rq, 0);
    pulse(8);
    probe(rq, v);
    chk("R10", rq, 1);
    chk("R10", v, 16'd67);
    wr(3'd3, 8'h00);

    // R8: second return, flag 3 still set, re-entry one boundary later
    ret_boundary(rq);
    chk("R8", rq, 0);
    probe(rq, v);
    chk("R8", rq, 1);
    chk("R8", v, 16'd27);

    // R11: software clear and hardware set of flag 0 in one cycle
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h00; src_evt = 12'h001;
    @(negedge clk);
    reg_we = 1'b0; src_evt = '0;
    rd(3'd2, d);
    chk("R11", d, 8'h01);

    // R12: field widths and unused locations
    wr(3'd4, 8'hFF);
    rd(3'd4, d);
    chk("R12", d, 8'hFF);
    wr(3'd5, 8'hFF);
    rd(3'd5, d);
    chk("R12", d, 8'h0F);
    wr(3'd1, 8'hFF);
    rd(3'd1, d);
    chk("R12", d, 8'h1F);
    wr(3'd6, 8'hFF);
    rd(3'd6, d);
    chk("R12", d, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule